// File: doc/BRIEF.md
# Correlated Double Sampling Hit Finder

This block takes a row of a pixel matrix one channel at a time. For every channel it is given two digitized samples: one taken before the row is cleared, which holds signal plus pedestal, and one taken after the clear, which holds the pedestal alone. The block subtracts the second from the first to get a signal free of pedestal. It compares that signal with a threshold the host has programmed. Only channels above the threshold leave a record. Each record holds the row, the column and the amplitude, and goes into an on-chip hit memory that works as a FIFO.

Channels arrive in ascending column order, one per cycle when `in_valid` is high. The column is counted inside the block, starting at zero and wrapping after the last channel. Each decision is made in the same cycle the sample arrives, so one full row of channels takes one cycle per channel. The host drains records from the memory head with a pop strobe. When the memory is full, further hits are dropped and a sticky flag records the loss.

Top module: `cds_hit_finder`

## Requirements
- R1: After reset the hit memory is empty (`rd_empty`=1, `hit_count`=0), `overflow` is 0, the column counter is 0 and the threshold is 0.
- R2: The amplitude of a record is the 13-bit two's-complement difference `in_first - in_second` of its channel.
- R3: A record is written only when that difference, as a signed number, is strictly greater than the threshold. A difference equal to the threshold, or a negative one, leaves no record.
- R4: A record is 27 bits wide: bits 26:20 hold the row from `in_row`, bits 19:13 hold the column, and bits 12:0 hold the amplitude.
- R5: Each valid sample takes the current column number, and the column then advances by one. After column 127 it returns to 0.
- R6: The host reads records in the order they were written. `rd_data` shows the oldest record, and `rd_en` removes it at the clock edge.
- R7: The memory holds 256 records. A hit that arrives while 256 records are stored is dropped, and `overflow` is set and stays set until reset.
- R8: `rd_en` while the memory is empty changes nothing.
- R9: A cycle with `thr_we` loads `thr_wdata` into the threshold. Samples in later cycles are compared against the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 12 | New threshold value |
| in_valid | input | 1 | A channel's sample pair is present |
| in_row | input | 7 | Row number of the current sample |
| in_first | input | 12 | Sample before clear (signal plus pedestal) |
| in_second | input | 12 | Sample after clear (pedestal) |
| rd_en | input | 1 | Remove the head record |
| rd_data | output | 27 | Head record {row, column, amplitude} |
| rd_empty | output | 1 | No record stored |
| hit_count | output | 9 | Number of stored records |
| overflow | output | 1 | Sticky: a hit was dropped |

## Verification
The assertions assume three things about the inputs. `in_row` stays constant across the 128 samples of a row, the host never writes the threshold in a cycle that carries a sample, and no input changes between clock edges. The stimulus keeps to this by driving every input on the falling edge, changing the row only after 128 samples, and writing the threshold only between rows. The sweeps cover many first and second sample pairs around the threshold and on both sides of it. They include differences exactly at the threshold, one count above it, and negative ones. A final phase fills the memory past its capacity without draining.

// File: rtl/cds_hit_finder.sv
module cds_hit_finder #(
  parameter int NCH   = 128,
  parameter int SW    = 12,
  parameter int RW    = 7,
  parameter int DEPTH = 256
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          thr_we,
  input  logic [SW-1:0]                                 thr_wdata,
  input  logic                                          in_valid,
  input  logic [RW-1:0]                                 in_row,
  input  logic [SW-1:0]                                 in_first,
  input  logic [SW-1:0]                                 in_second,
  input  logic                                          rd_en,
  output logic [RW+$clog2(NCH)+SW:0]                    rd_data,
  output logic                                          rd_empty,
  output logic [$clog2(DEPTH):0]                        hit_count,
  output logic                                          overflow
);
  localparam int CW = $clog2(NCH);
  localparam int DW = SW + 1;
  localparam int EW = RW + CW + DW;
  localparam int AW = $clog2(DEPTH);

  logic [SW-1:0]        thr_q;
  logic [CW-1:0]        col;
  logic [AW-1:0]        wr_ptr, rd_ptr;
  logic [AW:0]          count;
  logic [EW-1:0]        mem [DEPTH];
  logic signed [DW-1:0] diff;
  logic                 hit, full, push, pop;

  assign diff = $signed({1'b0, in_first}) - $signed({1'b0, in_second});
  assign hit  = in_valid && (diff > $signed({1'b0, thr_q}));
  assign full = (count == (AW+1)'(DEPTH));
  assign push = hit && !full;
  assign pop  = rd_en && (count != '0);

  assign rd_data   = mem[rd_ptr];
  assign rd_empty  = (count == '0);
  assign hit_count = count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q    <= '0;
      col      <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (thr_we) thr_q <= thr_wdata;
      if (in_valid) col <= (col == CW'(NCH-1)) ? '0 : col + 1'b1;
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
      if (hit && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= {in_row, col, diff};

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count <= (AW+1)'(DEPTH));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_ovf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !overflow && in_valid && hit_count != (AW+1)'(DEPTH) |=> !overflow);

  p_col_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && col == CW'(NCH-1) |=> col == '0);

  p_col_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(col));

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty && !in_valid |=> rd_empty && $stable(rd_ptr));

  p_below_thr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !thr_we && diff <= $signed({1'b0, thr_q}) && !rd_en |=> $stable(hit_count));

  p_neg_nohit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_first < in_second && !rd_en |=> $stable(hit_count));
endmodule

// File: tb/test_cds_hit_finder.sv
module test_cds_hit_finder;
  logic        clk = 1'b0;
  logic        rst_n, thr_we, in_valid, rd_en;
  logic [11:0] thr_wdata, in_first, in_second;
  logic [6:0]  in_row;
  logic [26:0] rd_data;
  logic        rd_empty, overflow;
  logic [8:0]  hit_count;

  int vectors = 0, errors = 0;
  bit done = 0;
  int tb_col = 0;
  int tb_thr = 0;
  logic [26:0] exp_q[$];

  always #4 clk = ~clk;

  cds_hit_finder i_cds_hit_finder (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(int row, int first, int second);
    int d;
    @(negedge clk);
    in_valid = 1; in_row = 7'(row); in_first = 12'(first); in_second = 12'(second);
    d = first - second;
    if (d > tb_thr && exp_q.size() < 256)
      exp_q.push_back({7'(row), 7'(tb_col), 13'(d)});
    tb_col = (tb_col == 127) ? 0 : tb_col + 1;
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic set_thr(int t);
    @(negedge clk);
    thr_we = 1; thr_wdata = 12'(t);
    @(negedge clk);
    thr_we = 0;
    tb_thr = t;
  endtask

  task automatic drain();
    @(negedge clk);
    chk("R7 count", 32'(hit_count), 32'(exp_q.size()));
    while (exp_q.size() != 0) begin
      chk("R6 empty", 32'(rd_empty), 0);
      chk("R2 R4 R6 record", 32'(rd_data), 32'(exp_q.pop_front()));
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
    end
    chk("R6 drained", 32'(rd_empty), 1);
  endtask

  task automatic do_reset();
    rst_n = 0; thr_we = 0; in_valid = 0; rd_en = 0;
    thr_wdata = 0; in_first = 0; in_second = 0; in_row = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    tb_col = 0; tb_thr = 0; exp_q.delete();
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk("R1 empty", 32'(rd_empty), 1);
    chk("R1 count", 32'(hit_count), 0);
    chk("R1 overflow", 32'(overflow), 0);
    // R1 threshold 0: diff 1 is a hit, diff 0 is not
    send(3, 10, 10);
    send(3, 11, 10);
    drain();
    // realign to column 0 (R5)
    for (int c = 2; c < 128; c++) send(3, 0, 0);
    // R3 R9 sweeps over thresholds and patterns
    for (int r = 0; r < 12; r++) begin
      set_thr((r * 347) % 4096);
      for (int c = 0; c < 128; c++) begin
        int f, s;
        case (c % 4)
          0: begin f = (c * 37 + r * 101) % 4096; s = (c * 53 + r * 7) % 4096; end
          1: begin s = (c * 13 + r) % 2048; f = s + tb_thr; if (f > 4095) f = 4095; end
          2: begin s = (c * 11) % 2000; f = s + tb_thr + 1; if (f > 4095) f = 4095; end
          default: begin f = (c * 5) % 300; s = f + 1 + r; end
        endcase
        send(r, f, s);
      end
      drain();
    end
    // R7 overflow: 384 hits, no draining
    set_thr(0);
    for (int i = 0; i < 384; i++) send(100, 100 + (i % 50), i % 7);
    @(negedge clk);
    chk("R7 full count", 32'(hit_count), 256);
    chk("R7 overflow set", 32'(overflow), 1);
    drain();
    // R8 pop on empty
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk("R8 count", 32'(hit_count), 0);
    chk("R8 empty", 32'(rd_empty), 1);
    chk("R7 sticky", 32'(overflow), 1);
    do_reset();
    chk("R1 overflow after reset", 32'(overflow), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule